// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an addressing request into the byte address a processor's load, store or branch will use. One request carries a 3-bit mode code, a base register value, an index register value, a 16-bit signed displacement, a 2-bit element size code and the current program counter. The direct modes (register-indirect, displacement, scaled index, auto-increment, PC-relative) produce their address combinationally in the cycle the request is presented, together with a misalignment flag and, for auto-increment, the updated base value to be written back.

The memory-indirect mode needs a pointer from memory first, so a three-state machine sequences it. From `IDLE` an indirect request moves to `FETCH_PTR` (transition *accept*), where the unit drives a pointer read at the base address and captures the returned word. It then always moves to `CHECK_PTR` (transition *capture*). There it either presents the pointer as the final address (transition *issue*, back to `IDLE`) or, when the pointer is not a multiple of four, raises an error pulse and returns to `IDLE` (transition *abort*). Any request offered while the machine is away from `IDLE` is dropped.

All address arithmetic is 32-bit and wraps modulo 2^32. The register file, the memory and the instruction decoder are outside the unit.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (register-indirect) presents `ea` equal to `base` with `ea_valid` high in the same cycle as `req_valid`.
- R2: Mode code 1 (displacement) presents `ea` equal to `base` plus `disp` sign-extended from 16 bits.
- R3: Mode code 2 (scaled) presents `ea` equal to `base` plus sign-extended `disp` plus `index` shifted left by `size`, where size code 0, 1, 2, 3 means 1, 2, 4, 8 bytes (base 400, index 3, code 2, disp 0 gives 412).
- R4: Mode code 3 (auto-increment) presents `ea` equal to `base` and raises `wb_en` with `wb_data` equal to `base` plus the element byte count; `wb_en` stays low in every other mode.
- R5: Mode code 4 (memory-indirect) produces no address in the accept cycle; in the next cycle `ptr_rd` is high with `ptr_addr` equal to `base`; in the cycle after that `ea_valid` is high with `ea` equal to the word returned on `mem_rdata`.
- R6: When the fetched pointer has either of its two low bits set, the final cycle raises `ind_err` instead of `ea_valid`.
- R7: Mode code 5 (PC-relative) presents `ea` equal to `pc` plus the sign-extended `disp` shifted left by two, and `misalign` stays low.
- R8: For all other modes, `misalign` is high in the same cycle as `ea_valid` exactly when `ea` is not a multiple of the element byte count; byte accesses (code 0) are never misaligned.
- R9: `busy` is high in `FETCH_PTR` and `CHECK_PTR`; a request presented while `busy` is high, or one carrying mode code 6 or 7, yields no `ea_valid`.
- R10: Every sum wraps modulo 2^32, for the address and for the write-back value.
- R11: After reset the machine is in `IDLE` with `busy`, `ptr_rd`, `ind_err` and `ea_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| size | input | 2 | Element size code (bytes = 1 << size) |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 16 | Signed displacement or branch offset |
| pc | input | 32 | Current program counter |
| mem_rdata | input | 32 | Pointer word returned for `ptr_addr` |
| ea_valid | output | 1 | Effective address valid |
| ea | output | 32 | Effective address |
| misalign | output | 1 | Access not on its natural boundary |
| wb_en | output | 1 | Base write-back request |
| wb_data | output | 32 | Updated base value |
| ptr_rd | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Pointer read address |
| ind_err | output | 1 | Indirect pointer not word aligned |
| busy | output | 1 | Indirect sequence in progress |

## Verification
Two functions can meet in one cycle: a direct request arriving while the pointer read of an indirect sequence is on the bus, and a write-back issued on an address that is also misaligned. The bench provokes the first by driving a displacement request during `FETCH_PTR` and judges that `ea_valid` stays low there while the indirect result still arrives intact one cycle later. The second is provoked by an auto-increment of 8-byte elements from an address that is only 4-byte aligned, where `misalign`, `wb_en` and the incremented base must all appear together.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        M_REGIND  = 3'd0,
        M_DISP    = 3'd1,
        M_SCALED  = 3'd2,
        M_AUTOINC = 3'd3,
        M_INDIR   = 3'd4,
        M_PCREL   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_FETCH_PTR = 2'd1,
        S_CHECK_PTR = 2'd2
    } state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DISPW   = 16,
    parameter int SZW     = 2,
    parameter int BR_SHIFT = 2
) (
    input  logic [2:0]     mode,
    input  logic [SZW-1:0] size,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  index,
    input  logic [DISPW-1:0] disp,
    input  logic [AW-1:0]  pc,
    output logic [AW-1:0]  addr,
    output logic [AW-1:0]  next_base
);
    localparam int EXTW = AW - DISPW;

    logic [AW-1:0] disp_x;
    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] elem_bytes;

    always_comb begin
        disp_x     = {{EXTW{disp[DISPW-1]}}, disp};
        scaled_idx = index << size;
        elem_bytes = AW'(1) << size;
        next_base  = base + elem_bytes;
        case (mode)
            M_DISP:   addr = base + disp_x;
            M_SCALED: addr = base + disp_x + scaled_idx;
            M_PCREL:  addr = pc + (disp_x << BR_SHIFT);
            default:  addr = base;
        endcase
    end
endmodule

// File: rtl/align_chk.sv
module align_chk #(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    output logic           bad
);
    localparam int NSZ = 1 << SZW;

    logic [NSZ-1:0] bad_by_size;

    for (genvar g = 0; g < NSZ; g++) begin : g_sz
        localparam logic [AW-1:0] LOWMASK = AW'((64'd1 << g) - 64'd1);
        assign bad_by_size[g] = |(addr & LOWMASK);
    end

    assign bad = bad_by_size[size];
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DISPW     = 16,
    parameter int SZW       = 2,
    parameter int BR_SHIFT  = 2,
    parameter int PTR_ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       mode,
    input  logic [SZW-1:0]   size,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    index,
    input  logic [DISPW-1:0] disp,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    mem_rdata,
    output logic             ea_valid,
    output logic [AW-1:0]    ea,
    output logic             misalign,
    output logic             wb_en,
    output logic [AW-1:0]    wb_data,
    output logic             ptr_rd,
    output logic [AW-1:0]    ptr_addr,
    output logic             ind_err,
    output logic             busy
);
    localparam logic [SZW-1:0] PTR_SIZE = SZW'(PTR_ALIGN);

    state_e        state_q, state_d;
    logic [AW-1:0] base_q;
    logic [AW-1:0] ptr_q;
    logic [SZW-1:0] size_q;

    logic [AW-1:0] calc_addr, calc_next;
    logic [AW-1:0] chk_addr;
    logic [SZW-1:0] chk_size;
    logic          chk_bad, ptr_bad;
    logic          idle, direct_ok, accept_ind;

    ea_calc #(.AW(AW), .DISPW(DISPW), .SZW(SZW), .BR_SHIFT(BR_SHIFT)) u_calc (
        .mode(mode), .size(size), .base(base), .index(index),
        .disp(disp), .pc(pc), .addr(calc_addr), .next_base(calc_next)
    );

    align_chk #(.AW(AW), .SZW(SZW)) u_acc_align (
        .addr(chk_addr), .size(chk_size), .bad(chk_bad)
    );

    align_chk #(.AW(AW), .SZW(SZW)) u_ptr_align (
        .addr(ptr_q), .size(PTR_SIZE), .bad(ptr_bad)
    );

    assign idle       = (state_q == S_IDLE);
    assign direct_ok  = (mode == M_REGIND) || (mode == M_DISP) || (mode == M_SCALED)
                     || (mode == M_AUTOINC) || (mode == M_PCREL);
    assign accept_ind = idle && req_valid && (mode == M_INDIR);

    // state register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
            size_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_ind) begin
                base_q <= base;
                size_q <= size;
            end
            if (state_q == S_FETCH_PTR) ptr_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (accept_ind) state_d = S_FETCH_PTR;
            S_FETCH_PTR: state_d = S_CHECK_PTR;
            S_CHECK_PTR: state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ea_valid = 1'b0;
        ea       = calc_addr;
        chk_addr = calc_addr;
        chk_size = size;
        misalign = 1'b0;
        wb_en    = 1'b0;
        wb_data  = calc_next;
        ptr_rd   = 1'b0;
        ptr_addr = base_q;
        ind_err  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy     = 1'b0;
                ea_valid = req_valid && direct_ok;
                misalign = ea_valid && chk_bad && (mode != M_PCREL);
                wb_en    = ea_valid && (mode == M_AUTOINC);
            end
            S_FETCH_PTR: begin
                ptr_rd = 1'b1;
            end
            S_CHECK_PTR: begin
                ea       = ptr_q;
                chk_addr = ptr_q;
                chk_size = size_q;
                ind_err  = ptr_bad;
                ea_valid = !ptr_bad;
                misalign = !ptr_bad && chk_bad;
            end
            default: busy = 1'b0;
        endcase
    end

    assert_wb_only_autoinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (ea_valid && mode == M_AUTOINC && !busy));

    assert_ptr_then_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd |=> (ea_valid ^ ind_err));

    assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ind_err |-> (!ea_valid && !misalign && $past(ptr_rd)));

    assert_branch_no_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && !busy && mode == M_PCREL) |-> !misalign);

    assert_byte_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && chk_size == '0) |-> !misalign);

    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd |-> (busy && !ea_valid && !wb_en));
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] base = '0, index = '0, pc = '0;
    logic [15:0] disp = '0;
    logic [31:0] mem_rdata;
    logic        ea_valid, misalign, wb_en, ptr_rd, ind_err, busy;
    logic [31:0] ea, wb_data, ptr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] tmem [0:15];

    always #10 clk = ~clk;

    assign mem_rdata = tmem[ptr_addr[5:2]];

    ea_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .size(size),
        .base(base), .index(index), .disp(disp), .pc(pc), .mem_rdata(mem_rdata),
        .ea_valid(ea_valid), .ea(ea), .misalign(misalign), .wb_en(wb_en),
        .wb_data(wb_data), .ptr_rd(ptr_rd), .ptr_addr(ptr_addr),
        .ind_err(ind_err), .busy(busy)
    );

    // vector: mode(3) size(2) base(32) index(32) disp(16) pc(32)
    localparam int NV = 14;
    localparam logic [116:0] VEC [0:NV-1] = '{
        {3'd0, 2'd2, 32'h0000_1000, 32'd0, 16'h0000, 32'd0},
        {3'd0, 2'd2, 32'h0000_1002, 32'd0, 16'h0000, 32'd0},
        {3'd1, 2'd3, 32'h0000_2000, 32'd0, 16'h0010, 32'd0},
        {3'd1, 2'd1, 32'h0000_2000, 32'd0, 16'hFFFF, 32'd0},
        {3'd2, 2'd2, 32'd400,       32'd3, 16'h0000, 32'd0},
        {3'd2, 2'd3, 32'h0000_0100, 32'd5, 16'h0008, 32'd0},
        {3'd2, 2'd0, 32'h0000_0007, 32'd9, 16'hFFFE, 32'd0},
        {3'd3, 2'd2, 32'h0000_3000, 32'd0, 16'h0000, 32'd0},
        {3'd3, 2'd3, 32'h0000_3004, 32'd0, 16'h0000, 32'd0},
        {3'd5, 2'd2, 32'd0,         32'd0, 16'hFFFF, 32'h0000_0400},
        {3'd5, 2'd2, 32'd0,         32'd0, 16'h0003, 32'h0000_0402},
        {3'd1, 2'd2, 32'hFFFF_FFF0, 32'd0, 16'h0020, 32'd0},
        {3'd3, 2'd2, 32'hFFFF_FFFC, 32'd0, 16'h0000, 32'd0},
        {3'd6, 2'd2, 32'h0000_1000, 32'd0, 16'h0000, 32'd0}
    };

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    // expected {valid, misalign, wb, ea, wb_data}
    function automatic logic [66:0] model(input logic [116:0] v);
        logic [2:0]  m;
        logic [1:0]  s;
        logic [31:0] b, ix, p, dx, a, nb, nbytes;
        logic        vld, mis, wb;
        {m, s, b, ix, dx[15:0], p} = v;
        dx  = {{16{dx[15]}}, dx[15:0]};
        nbytes = 32'd1 << s;
        vld = (m <= 3'd3) || (m == 3'd5);
        case (m)
            3'd1:    a = b + dx;
            3'd2:    a = b + dx + ix * nbytes;
            3'd5:    a = p + dx * 32'd4;
            default: a = b;
        endcase
        nb  = b + nbytes;
        mis = vld && (m != 3'd5) && ((a % nbytes) != 0);
        wb  = (m == 3'd3);
        if (!vld) a = '0;
        return {vld, mis, wb, a, (wb ? nb : 32'd0)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [66:0] act,
                         input logic [66:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_ind(input logic [31:0] b, input logic [1:0] s, input bit collide,
                           input logic [31:0] exp_ea, input bit exp_mis, input bit exp_err);
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd4; base = b; size = s;
        #2;
        check(!ea_valid && !busy && !ptr_rd, "R5", {64'd0, ea_valid, busy, ptr_rd}, '0);
        @(negedge clk);
        req_valid = collide; mode = 3'd1; base = 32'h0000_5000; disp = 16'h0004;
        #2;
        check(ptr_rd && busy && ptr_addr == b, "R5", {34'd0, ptr_rd, busy, ptr_addr},
              {34'd0, 1'b1, 1'b1, b});
        if (collide)
            check(!ea_valid, "R9", {66'd0, ea_valid}, '0);
        @(negedge clk);
        req_valid = 1'b0; disp = '0;
        #2;
        if (exp_err)
            check(ind_err && !ea_valid, "R6", {65'd0, ind_err, ea_valid}, {65'd0, 2'b10});
        else
            check(ea_valid && !ind_err && ea == exp_ea && misalign == exp_mis,
                  exp_mis ? "R8" : "R5",
                  {32'd0, ea_valid, ind_err, misalign, ea},
                  {32'd0, 1'b1, 1'b0, exp_mis, exp_ea});
        @(negedge clk);
        #2;
        check(!busy && !ea_valid, "R9", {65'd0, busy, ea_valid}, '0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tmem[i] = 32'h0000_8000 + 32'(i * 4);
        tmem[3] = 32'h0000_8001;

        repeat (3) @(negedge clk);
        #2;
        check(!busy && !ptr_rd && !ind_err && !ea_valid, "R11",
              {63'd0, busy, ptr_rd, ind_err, ea_valid}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [66:0] exp, act;
            @(negedge clk);
            req_valid = 1'b1;
            {mode, size, base, index, disp, pc} = VEC[i];
            #2;
            exp = model(VEC[i]);
            act = {ea_valid, misalign, wb_en, (ea_valid ? ea : 32'd0),
                   (wb_en ? wb_data : 32'd0)};
            check(act == exp, tag_of(mode), act, exp);
            if (misalign != exp[65])
                check(1'b0, "R8", {66'd0, misalign}, {66'd0, exp[65]});
            if (i == 11 || i == 12)
                check(act == exp, "R10", act, exp);
        end

        // hand-computed example for R3
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd2; size = 2'd2; base = 32'd400; index = 32'd3; disp = '0;
        #2;
        check(ea_valid && ea == 32'd412, "R3", {35'd0, ea}, {35'd0, 32'd412});
        // write-back and misalignment together
        @(negedge clk);
        mode = 3'd3; size = 2'd3; base = 32'h0000_0104;
        #2;
        check(wb_en && misalign && wb_data == 32'h0000_010C, "R4",
              {33'd0, wb_en, misalign, wb_data}, {33'd0, 2'b11, 32'h0000_010C});
        @(negedge clk);
        req_valid = 1'b0;

        run_ind(32'h0000_0008, 2'd2, 1'b0, 32'h0000_8008, 1'b0, 1'b0);
        run_ind(32'h0000_0004, 2'd3, 1'b1, 32'h0000_8004, 1'b1, 1'b0);
        run_ind(32'h0000_000C, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);

        // reset in the middle of a sequence
        @(negedge clk);
        req_valid = 1'b1; mode = 3'd4; base = 32'h0000_0010;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        #2;
        check(!busy && !ptr_rd && !ea_valid && !ind_err, "R11",
              {63'd0, busy, ptr_rd, ea_valid, ind_err}, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule